// File: doc/BRIEF.md
# Multiplexed Scan Chain Wrapper

This block wraps a small example state machine, a 4-bit accumulator with a 4-bit event counter, so that every state bit is held in a multiplexed scan flip-flop. When the test-control input is low, each flip-flop loads its functional next state. When it is high, the flip-flops form one or more shift registers, and a tester can load or read the complete machine state through pins.

The state bits are spread over a parameterised number of chains. Scan data enters each chain on one of the functional data input pins and leaves on the matching functional output pin. Test control is therefore the only pin added to the machine. A full load or unload takes as many clocks as the longest chain has bits. A typical test loads a state, drops test control for one capture clock, and then shifts the captured state out while the next state is shifted in.

Top module: `scan_wrap`

## Requirements
- R1: While rst_ni is low, all state bits are cleared at once, without waiting for a clock edge. With test_i low, data_o then reads 0.
- R2: With test_i = 0 and en_i = 1, each rising clock edge updates the state. The accumulator (state bits 3:0) becomes acc + data_i modulo 16, and the counter (state bits 7:4) becomes cnt + 1 modulo 16. With en_i = 0, the state holds.
- R3: With test_i = 1, each rising clock edge loads state bit i from data_i[i] when i < NUM_CHAINS, and otherwise from state bit i - NUM_CHAINS.
- R4: Chain k holds the state bits whose index modulo NUM_CHAINS equals k. Its serial output is its highest-indexed bit, so a loaded pattern comes out of it highest index first.
- R5: In test mode, data_o[k] shows the serial output of chain k for every k < NUM_CHAINS. The remaining data_o bits, and all data_o bits in functional mode, show accumulator bit k.
- R6: With test_i = 1, en_i has no effect: shifting happens whatever its value.
- R7: Any 8-bit state can be loaded in ceil(8 / NUM_CHAINS) shift clocks. It can then be captured through one functional clock and unloaded in the same number of shift clocks.
- R8: Asserting rst_ni low clears the state in test mode as well as in functional mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for every state flip-flop |
| rst_ni | input | 1 | Active-low asynchronous reset |
| test_i | input | 1 | 1 selects scan shift, 0 selects functional operation |
| en_i | input | 1 | Functional update enable |
| data_i | input | ACC_W | Functional addend, also the serial input of chain k on bit k |
| data_o | output | ACC_W | Accumulator value, also the serial output of chain k on bit k in test mode |

## Verification
The bench builds two copies of the wrapper. The first uses three chains over eight bits, which gives chains of three, three and two bits: unequal lengths, a short chain that drops bits during a longer load, and one output pin that stays functional during test. The second uses a single eight-bit chain and exercises the longest shift path. Both copies receive the same stimulus and are compared every clock against a bench model of the shift and update rules. An explicit load, capture and unload is checked pin by pin on the three-chain copy.

// File: rtl/scan_wrap_pkg.sv
package scan_wrap_pkg;
  // bits in chain k for s state bits over c chains
  function automatic int chain_len(int s, int c, int k);
    return (s - k + c - 1) / c;
  endfunction

  // highest state index held by chain k (its serial output)
  function automatic int last_idx(int s, int c, int k);
    return k + c * ((s - 1 - k) / c);
  endfunction
endpackage

// File: rtl/scan_cell.sv
module scan_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic test_i,
  input  logic d_i,
  input  logic sd_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= test_i ? sd_i : d_i;
  end

  assign q_o = q_q;

  p_shift_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i |=> q_o == $past(sd_i));
  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_i |=> q_o == $past(d_i));
endmodule

// File: rtl/scan_next_state.sv
module scan_next_state #(
  parameter int ACC_W = 4,
  parameter int CNT_W = 4,
  localparam int ST_W = ACC_W + CNT_W
) (
  input  logic [ST_W-1:0]  state_i,
  input  logic             en_i,
  input  logic [ACC_W-1:0] add_i,
  output logic [ST_W-1:0]  next_o
);
  logic [ACC_W-1:0] acc;
  logic [CNT_W-1:0] cnt;

  assign acc = state_i[ACC_W-1:0];
  assign cnt = state_i[ST_W-1:ACC_W];

  always_comb begin
    next_o = state_i;
    if (en_i) next_o = {cnt + CNT_W'(1), acc + add_i};
  end
endmodule

// File: rtl/scan_pin_mux.sv
module scan_pin_mux #(
  parameter int OUT_W      = 4,
  parameter int NUM_CHAINS = 3
) (
  input  logic                  test_i,
  input  logic [OUT_W-1:0]      func_i,
  input  logic [NUM_CHAINS-1:0] so_i,
  output logic [OUT_W-1:0]      pin_o
);
  for (genvar k = 0; k < OUT_W; k++) begin : g_pin
    if (k < NUM_CHAINS) begin : g_shared
      assign pin_o[k] = test_i ? so_i[k] : func_i[k];
    end else begin : g_func
      assign pin_o[k] = func_i[k];
    end
  end
endmodule

// File: rtl/scan_wrap.sv
module scan_wrap #(
  parameter int ACC_W      = 4,
  parameter int CNT_W      = 4,
  parameter int NUM_CHAINS = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             test_i,
  input  logic             en_i,
  input  logic [ACC_W-1:0] data_i,
  output logic [ACC_W-1:0] data_o
);
  import scan_wrap_pkg::*;

  localparam int ST_W = ACC_W + CNT_W;

  logic [ST_W-1:0]       state_q;
  logic [ST_W-1:0]       next_d;
  logic [ST_W-1:0]       scan_d;
  logic [NUM_CHAINS-1:0] scan_out;

  scan_next_state #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_next (
    .state_i(state_q),
    .en_i   (en_i),
    .add_i  (data_i),
    .next_o (next_d)
  );

  for (genvar i = 0; i < ST_W; i++) begin : g_bit
    if (i < NUM_CHAINS) begin : g_head
      assign scan_d[i] = data_i[i];
    end else begin : g_link
      assign scan_d[i] = state_q[i-NUM_CHAINS];
    end
    scan_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .test_i(test_i),
      .d_i   (next_d[i]),
      .sd_i  (scan_d[i]),
      .q_o   (state_q[i])
    );
  end

  for (genvar k = 0; k < NUM_CHAINS; k++) begin : g_chain
    localparam int LAST = last_idx(ST_W, NUM_CHAINS, k);
    localparam int LEN  = chain_len(ST_W, NUM_CHAINS, k);
    assign scan_out[k] = state_q[LAST];

    if (LEN > 1) begin : g_flow
      // one shift moves the second-to-last bit onto the pin
      p_scan_out_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        test_i && $past(test_i) |-> data_o[k] == $past(state_q[LAST-NUM_CHAINS]));
    end
  end

  scan_pin_mux #(.OUT_W(ACC_W), .NUM_CHAINS(NUM_CHAINS)) u_pins (
    .test_i(test_i),
    .func_i(state_q[ACC_W-1:0]),
    .so_i  (scan_out),
    .pin_o (data_o)
  );

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_i && !en_i |=> $stable(state_q));
endmodule

// File: tb/scan_wrap_tb.sv
`timescale 1ns/1ps
module scan_wrap_tb;
  localparam int S  = 8;
  localparam int CA = 3;
  localparam int CB = 1;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       test_i = 1'b0;
  logic       en_i = 1'b0;
  logic [3:0] data_i = '0;
  logic [3:0] out_a, out_b;

  logic [7:0] exp_a, exp_b;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  scan_wrap #(.NUM_CHAINS(CA)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .test_i(test_i), .en_i(en_i),
    .data_i(data_i), .data_o(out_a));

  scan_wrap #(.NUM_CHAINS(CB)) u_dut_c1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .test_i(test_i), .en_i(en_i),
    .data_i(data_i), .data_o(out_b));

  function automatic logic [7:0] next_model(logic [7:0] st, logic t, logic e,
                                            logic [3:0] d, int c);
    logic [7:0] n;
    n = st;
    if (t) begin
      for (int i = 0; i < S; i++) n[i] = (i < c) ? d[i] : st[i-c];
    end else if (e) begin
      n[3:0] = st[3:0] + d;
      n[7:4] = st[7:4] + 4'd1;
    end
    return n;
  endfunction

  function automatic logic [3:0] out_model(logic [7:0] st, logic t, int c);
    logic [3:0] o;
    for (int k = 0; k < 4; k++)
      o[k] = (t && k < c) ? st[k + c * ((S - 1 - k) / c)] : st[k];
    return o;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_pins(string req);
    check({req, " 3-chain pins"}, {4'h0, out_a}, {4'h0, out_model(exp_a, test_i, CA)});
    check({req, " 1-chain pins"}, {4'h0, out_b}, {4'h0, out_model(exp_b, test_i, CB)});
  endtask

  task automatic step(string req);
    @(posedge clk_i);
    exp_a = next_model(exp_a, test_i, en_i, data_i, CA);
    exp_b = next_model(exp_b, test_i, en_i, data_i, CB);
    #1;
    check_pins(req);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    #1;
    exp_a = '0; exp_b = '0;
    check("R1 reset", {4'h0, out_a}, 8'h00);
    check_pins("R1 reset");
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
  endtask

  task automatic t_functional();
    test_i = 1'b0; en_i = 1'b1;
    data_i = 4'd5;  step("R2 add");
    data_i = 4'd9;  step("R2 add");
    data_i = 4'd15; step("R2 wrap");
    en_i = 1'b0; data_i = 4'd7; step("R2 hold");
    check("R2 acc value", {4'h0, out_a}, 8'h0D);
  endtask

  task automatic t_shift();
    test_i = 1'b1; en_i = 1'b0;
    data_i = 4'b1011; step("R3 shift");
    data_i = 4'b0110; step("R3 shift");
    en_i = 1'b1;
    data_i = 4'b1101; step("R6 enable ignored");
    data_i = 4'b0001; step("R6 enable ignored");
    en_i = 1'b0;
    for (int t = 0; t < 6; t++) begin
      data_i = 4'(t * 3 + 1);
      step("R5 scan pins");
    end
  endtask

  task automatic t_load_capture(logic [7:0] pat);
    int len;
    test_i = 1'b1; en_i = 1'b0;
    for (int t = 0; t < 3; t++) begin
      for (int k = 0; k < CA; k++)
        data_i[k] = (k + CA * (2 - t) < S) ? pat[k + CA * (2 - t)] : 1'b0;
      data_i[3] = 1'b0;
      step("R7 load");
    end
    // unload the three-chain copy pin by pin, highest index first
    data_i = '0;
    for (int t = 0; t < 3; t++) begin
      for (int k = 0; k < CA; k++) begin
        len = (S - k + CA - 1) / CA;
        if (t < len)
          check("R4 unload order", {7'h0, out_a[k]}, {7'h0, pat[k + CA * (len - 1 - t)]});
      end
      step("R4 unload");
    end
    // reload, then capture one functional clock, then unload through model
    for (int t = 0; t < 3; t++) begin
      for (int k = 0; k < CA; k++)
        data_i[k] = (k + CA * (2 - t) < S) ? pat[k + CA * (2 - t)] : 1'b0;
      data_i[3] = 1'b0;
      step("R7 reload");
    end
    check("R7 loaded acc", {4'h0, out_model(exp_a, 1'b0, CA)}, {4'h0, pat[3:0]});
    test_i = 1'b0; en_i = 1'b1; data_i = 4'd3;
    step("R7 capture");
    check("R7 capture acc", {4'h0, out_a}, {4'h0, pat[3:0] + 4'd3});
    test_i = 1'b1; en_i = 1'b0; data_i = '0;
    for (int t = 0; t < 3; t++) step("R7 capture unload");
  endtask

  task automatic t_reset_in_test();
    test_i = 1'b1; data_i = 4'hF;
    step("R8 fill"); step("R8 fill");
    rst_ni = 1'b0;
    #1;
    exp_a = '0; exp_b = '0;
    check_pins("R8 reset in test");
    test_i = 1'b0;
    #1;
    check("R8 functional view", {4'h0, out_a}, 8'h00);
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    exp_a = '0; exp_b = '0;
    #1;
    t_reset();
    t_functional();
    t_shift();
    t_load_capture(8'hA5);
    t_load_capture(8'h3C);
    t_reset_in_test();
    t_functional();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule